// File: doc/BRIEF.md
# UART with break detection

This block is an asynchronous serial transmitter and receiver for 8-bit frames. Each frame on the wire is a low start bit, eight data bits sent least significant bit first, and a high stop bit. The idle line level is high. All timing comes from a single-cycle enable, `tick16`, which pulses at sixteen times the bit rate. Each bit therefore lasts sixteen ticks.

The transmitter has a holding register in front of its shift register. Software can queue a second byte while the first is still going out. The queued byte starts as soon as the current stop bit ends, with no idle gap.

The receiver first synchronises the line. It confirms a start bit at the eighth tick, then samples every later bit at its middle. It reports the stop bit it saw, and it flags a framing error when that stop bit is low. It also flags a line break when the line stays low for eleven bit times in a row, and it delivers no byte for that frame.

Transmit states:
- `TX_IDLE`: the line is high.
- `TX_START`, `TX_DATA`, `TX_STOP`: one bit period each. `TX_DATA` repeats eight times.
- Transitions:
  - `TX_IDLE`→`TX_START` when the holding register is full.
  - `TX_START`→`TX_DATA` at the end of the bit.
  - `TX_DATA`→`TX_STOP` after the eighth bit.
  - `TX_STOP`→`TX_START` when a byte is queued.
  - `TX_STOP`→`TX_IDLE` otherwise.

Receive states:
- `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_STOP`.
- `RX_EXTRA`: the eleventh-bit check.
- `RX_HOLD`: waits for the line to return high.
- Transitions:
  - `RX_IDLE`→`RX_START` on a low line.
  - `RX_START`→`RX_IDLE` on a glitch.
  - `RX_START`→`RX_DATA` on a confirmed start.
  - `RX_DATA`→`RX_STOP` after eight bits.
  - `RX_STOP`→`RX_IDLE` on a high stop bit.
  - `RX_STOP`→`RX_HOLD` on a low stop bit with nonzero data.
  - `RX_STOP`→`RX_EXTRA` on a low stop bit with all-zero data.
  - `RX_EXTRA`→`RX_IDLE` when the line is high.
  - `RX_EXTRA`→`RX_HOLD` when the line is low (break).
  - `RX_HOLD`→`RX_IDLE` when the line is high.

Top module: `uart_brk_core`

## Requirements
- R1: While `rst_n` is low and right after it, `txd` is 1 and `tx_empty` is 1. `rx_ready`, `frame_err`, `brk_det` and `wr_ovr` are 0.
- R2: A transmitted frame has these bits, each lasting 16 ticks: start 0, data bits 0 to 7, stop 1. A looped-back byte is received unchanged.
- R3: A write made while a frame is shifting and the holding register is empty is accepted, and `tx_empty` drops to 0. The queued frame's start bit follows the previous stop bit directly, so the stop bit is high for exactly 16 ticks.
- R4: A write made while the holding register is full and a frame is shifting is dropped and sets `wr_ovr`. A dropped byte is never sent.
- R5: A low level that is high again at the eighth tick after start detection is ignored, and no byte is delivered.
- R6: A received frame with a high stop bit gives a one-cycle `rx_ready` pulse, with `rx_data` holding the byte and `rx_stop` = 1.
- R7: A received frame whose stop bit is low is still delivered, with `rx_stop` = 0, and it sets `frame_err`. The receiver then waits for a high line before it accepts a new start.
- R8: Eleven consecutive low mid-bit samples (start, eight data, stop, one more) set `brk_det`, and no byte is delivered. Reception resumes after the line goes high.
- R9: Exactly ten low bit times followed by a high line is a framing error carrying byte 0x00, not a break.
- R10: `brk_det`, `frame_err` and `wr_ovr` stay set until a `flag_clr` pulse. A new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Transmit write strobe |
| wr_data | input | 8 | Byte to transmit |
| flag_clr | input | 1 | Clears the sticky flags |
| rxd | input | 1 | Receive line |
| txd | output | 1 | Transmit line |
| tx_empty | output | 1 | Holding register is free |
| wr_ovr | output | 1 | A write was dropped (sticky) |
| rx_data | output | 8 | Last delivered byte |
| rx_stop | output | 1 | Stop bit of the last delivered byte |
| rx_ready | output | 1 | One-cycle pulse when a byte is delivered |
| frame_err | output | 1 | Low stop bit seen (sticky) |
| brk_det | output | 1 | Line break seen (sticky) |

## Verification
The hardest condition to reach is the boundary between a framing error and a break. An all-zero byte with a low stop bit must produce eleven low samples for a break, and only ten when the line rises one bit time earlier. The bench drives the raw receive line for exactly ten and exactly twelve bit times and checks that the first delivers 0x00 with a framing error, while the second sets the break flag and delivers nothing.

The gapless double-buffer hand-off is reached by writing two bytes one cycle apart while the transmit output is looped back. The first byte is 0x55, so every high run on the line lasts one bit. A stop bit longer than 64 clocks before the second start bit would therefore show an idle gap.

// File: rtl/uart_brk_pkg.sv
`timescale 1ns/1ps
package uart_brk_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_EXTRA, RX_HOLD} rx_st_t;
endpackage

// File: rtl/uart_brk_tx.sv
`timescale 1ns/1ps
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_clr,
    output logic              txd,
    output logic              tx_empty,
    output logic              wr_ovr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_st_t             st, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  sh, hold;
    logic               hold_full, ovr;
    logic               bit_end, load, accept;

    assign bit_end = tick && (cnt == CNT_LAST);
    assign load    = hold_full && ((st == TX_IDLE) || (st == TX_STOP && bit_end));
    assign accept  = wr_en && (!hold_full || load);

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:  if (hold_full) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && idx == IDX_LAST) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = hold_full ? TX_START : TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= TX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            sh        <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            ovr       <= 1'b0;
        end else begin
            st <= nxt;
            if (st == TX_IDLE)  cnt <= '0;
            else if (tick)      cnt <= bit_end ? '0 : cnt + 1'b1;
            if (st != TX_DATA)  idx <= '0;
            else if (bit_end)   idx <= idx + 1'b1;
            if (load)                          sh <= hold;
            else if (st == TX_DATA && bit_end) sh <= sh >> 1;
            if (accept) begin
                hold      <= wr_data;
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end
            if (wr_en && !accept) ovr <= 1'b1;
            else if (flag_clr)    ovr <= 1'b0;
        end
    end

    always_comb begin
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
        tx_empty = !hold_full;
        wr_ovr   = ovr;
    end

    p_drop_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_full && st == TX_DATA) |=> wr_ovr);
    p_queue_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st != TX_IDLE && tx_empty) |=> !tx_empty);
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_STOP) |-> txd);
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ovr && !flag_clr) |=> wr_ovr);
endmodule

// File: rtl/uart_brk_rx.sv
`timescale 1ns/1ps
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_stop,
    output logic              rx_ready,
    output logic              frame_err,
    output logic              brk_det
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_st_t            st, nxt;
    logic              rs1, rs2;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh, data_q;
    logic              rdy_q, stop_q, ferr_q, brk_q;
    logic              mid, samp, deliver, stop_val, brk_hit;

    assign mid      = tick && (cnt == CNT_MID);
    assign samp     = tick && (cnt == CNT_LAST);
    assign deliver  = samp && (((st == RX_STOP) && (rs2 || sh != '0)) ||
                               ((st == RX_EXTRA) && rs2));
    assign stop_val = (st == RX_STOP) && rs2;
    assign brk_hit  = samp && (st == RX_EXTRA) && !rs2;

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE:  if (!rs2) nxt = RX_START;
            RX_START: if (mid) nxt = rs2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (samp && idx == IDX_LAST) nxt = RX_STOP;
            RX_STOP:  if (samp) nxt = rs2 ? RX_IDLE : ((sh == '0) ? RX_EXTRA : RX_HOLD);
            RX_EXTRA: if (samp) nxt = rs2 ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rs2) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RX_IDLE;
            rs1    <= 1'b1;
            rs2    <= 1'b1;
            cnt    <= '0;
            idx    <= '0;
            sh     <= '0;
            data_q <= '0;
            rdy_q  <= 1'b0;
            stop_q <= 1'b0;
            ferr_q <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            st  <= nxt;
            rs1 <= rxd;
            rs2 <= rs1;
            if (st == RX_IDLE || st == RX_HOLD) cnt <= '0;
            else if (tick) cnt <= ((st == RX_START && cnt == CNT_MID) || cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            if (st != RX_DATA) idx <= '0;
            else if (samp)     idx <= idx + 1'b1;
            if (st == RX_DATA && samp) sh <= {rs2, sh[DATA_W-1:1]};
            rdy_q <= deliver;
            if (deliver) begin
                data_q <= sh;
                stop_q <= stop_val;
            end
            if (deliver && !stop_val) ferr_q <= 1'b1;
            else if (flag_clr)        ferr_q <= 1'b0;
            if (brk_hit)              brk_q <= 1'b1;
            else if (flag_clr)        brk_q <= 1'b0;
        end
    end

    always_comb begin
        rx_data   = data_q;
        rx_stop   = stop_q;
        rx_ready  = rdy_q;
        frame_err = ferr_q;
        brk_det   = brk_q;
    end

    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> !rx_ready);
    p_low_stop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_stop) |-> frame_err);
    p_brk_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_det && !flag_clr) |=> brk_det);
    p_brk_no_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> !rx_ready);
    p_glitch_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && mid && rs2) |=> (st == RX_IDLE));
endmodule

// File: rtl/uart_brk_core.sv
`timescale 1ns/1ps
module uart_brk_core #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_empty,
    output logic              wr_ovr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_stop,
    output logic              rx_ready,
    output logic              frame_err,
    output logic              brk_det
);
    uart_brk_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .txd(txd), .tx_empty(tx_empty), .wr_ovr(wr_ovr)
    );

    uart_brk_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd), .flag_clr(flag_clr),
        .rx_data(rx_data), .rx_stop(rx_stop), .rx_ready(rx_ready),
        .frame_err(frame_err), .brk_det(brk_det)
    );
endmodule

// File: tb/sim_uart_brk_core.sv
`timescale 1ns/1ps
module sim_uart_brk_core;
    localparam int BIT_CLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flag_clr = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       loop_en = 1'b0;
    logic       rxd;
    logic       txd, tx_empty, wr_ovr, rx_stop, rx_ready, frame_err, brk_det;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int rx_count = 0;
    logic [8:0] exp_q[$];
    logic [1:0] tdiv = '0;
    int run_len = 0;
    int falls = 0;
    int gap_len = 0;
    logic prev_txd = 1'b1;
    bit done = 1'b0;

    assign rxd = loop_en ? txd : rxd_drv;

    uart_brk_core u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .rxd(rxd), .txd(txd), .tx_empty(tx_empty), .wr_ovr(wr_ovr),
        .rx_data(rx_data), .rx_stop(rx_stop), .rx_ready(rx_ready),
        .frame_err(frame_err), .brk_det(brk_det)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= tdiv + 1'b1;
        tick16 <= (tdiv == 2'd3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected items as bytes are delivered
    always @(negedge clk) begin
        if (rst_n && rx_ready) begin
            rx_count++;
            if (exp_q.size() == 0) begin
                chk("R6 unexpected byte", {23'd0, rx_stop, rx_data}, 32'h1ff);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R6/R7 received byte and stop bit", {23'd0, rx_stop, rx_data}, {23'd0, e});
            end
        end
    end

    // high-run length before each falling edge of txd (R3 gap check)
    always @(negedge clk) begin
        if (txd) run_len++;
        else begin
            if (prev_txd) begin
                falls++;
                if (falls == 6) gap_len = run_len;
            end
            run_len = 0;
        end
        prev_txd = txd;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stopv);
        rxd_drv = 1'b0;
        cyc(BIT_CLK);
        for (int b = 0; b < 8; b++) begin
            rxd_drv = d[b];
            cyc(BIT_CLK);
        end
        rxd_drv = stopv;
        cyc(BIT_CLK);
        rxd_drv = 1'b1;
        cyc(2 * BIT_CLK);
    endtask

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        cyc(10);
        chk("R1 txd at reset", txd, 1);
        chk("R1 tx_empty at reset", tx_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_ready after reset", rx_ready, 0);
        chk("R1 frame_err after reset", frame_err, 0);
        chk("R1 brk_det after reset", brk_det, 0);
        chk("R1 wr_ovr after reset", wr_ovr, 0);
        cyc(20);

        // R2/R3/R4: loopback, double-buffered writes, dropped third write
        loop_en = 1'b1;
        falls = 0;
        exp_q.push_back({1'b1, 8'h55});
        write_byte(8'h55);
        exp_q.push_back({1'b1, 8'hA5});
        write_byte(8'hA5);
        chk("R3 tx_empty low after queued write", tx_empty, 0);
        write_byte(8'h7E);
        chk("R4 wr_ovr after write with full buffer", wr_ovr, 1);
        cyc(25 * BIT_CLK);
        chk("R2 both looped-back bytes received", rx_count, 2);
        chk("R4 dropped byte never sent", exp_q.size(), 0);
        chk("R3 stop bit length before queued frame", gap_len, BIT_CLK);
        chk("R3 tx_empty after both frames", tx_empty, 1);
        chk("R10 wr_ovr still set before clear", wr_ovr, 1);
        clear_flags();
        chk("R10 wr_ovr cleared", wr_ovr, 0);
        loop_en = 1'b0;
        cyc(BIT_CLK);

        // R7: framing error, byte still delivered
        exp_q.push_back({1'b0, 8'h81});
        send_frame(8'h81, 1'b0);
        chk("R7 frame_err on low stop", frame_err, 1);
        chk("R7 no break on framing error", brk_det, 0);
        clear_flags();
        chk("R10 frame_err cleared", frame_err, 0);

        // R9: ten low bit times then high is a framing error with 0x00
        exp_q.push_back({1'b0, 8'h00});
        send_frame(8'h00, 1'b0);
        chk("R9 frame_err on ten low bits", frame_err, 1);
        chk("R9 no break on ten low bits", brk_det, 0);
        clear_flags();

        // R5: short low glitch is ignored
        base = rx_count;
        rxd_drv = 1'b0;
        cyc(12);
        rxd_drv = 1'b1;
        cyc(3 * BIT_CLK);
        chk("R5 no byte from glitch", rx_count, base);
        exp_q.push_back({1'b1, 8'h5A});
        send_frame(8'h5A, 1'b1);
        chk("R5 receiver usable after glitch", rx_count, base + 1);
        chk("R6 no framing error on good frame", frame_err, 0);

        // R8: twelve low bit times is a break, no byte delivered
        base = rx_count;
        rxd_drv = 1'b0;
        cyc(12 * BIT_CLK);
        chk("R8 brk_det while line low", brk_det, 1);
        rxd_drv = 1'b1;
        cyc(3 * BIT_CLK);
        chk("R8 no byte during break", rx_count, base);
        chk("R10 brk_det sticky", brk_det, 1);
        clear_flags();
        chk("R10 brk_det cleared", brk_det, 0);
        exp_q.push_back({1'b1, 8'hC3});
        send_frame(8'hC3, 1'b1);
        chk("R8 reception resumes after break", rx_count, base + 1);
        chk("R6 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule